// File: doc/BRIEF.md
# Rational Fractional Clock Divider

This block derives a slower event train from a fast system clock. The output rate is an exact rational fraction of the clock rate, set by an integer numerator and an integer denominator. The core is a phase accumulator. Every enabled cycle, the numerator is added to it. When the sum would run past the denominator, the denominator is taken off and an output event is produced. Because the accumulator wraps at the denominator, not at a power of two, the long-run ratio is exactly numerator/denominator. Each edge still falls on a system-clock boundary, so edges can sit up to one clock period away from their ideal position. When the ratio is an integer division, the event spacing is constant.

Two output modes are offered. In pulse mode the output goes high for one system clock per event, which gives an average rate of Fsys·num/den. In toggle mode the output flips on each event, which gives a rectangular wave at Fsys·num/(2·den) with a duty cycle as near 50% as the event spacing allows. The output comes straight from a flip-flop, so no combinational glitch reaches it. A separate strobe marks every overflow in either mode. An invalid ratio, one with a zero denominator or a numerator not below the denominator, is flagged and silences the block.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst_n` is low at a rising edge, the accumulator is cleared to zero and both `clk_out` and `wrap_stb` are low in the following cycle.
- R2: On an enabled step with a valid ratio, an event occurs exactly when the accumulator is greater than den−num. `wrap_stb` is high for one cycle in the cycle after each event step and low after every other step.
- R3: On an event step the accumulator becomes acc+num−den, otherwise acc+num. Starting from zero, n steps yield exactly floor((n·num−1)/den) events, and the accumulator never exceeds den.
- R4: With `mode` = 0 (pulse), `clk_out` after each enabled step equals `wrap_stb`, so it is high for one clock per event.
- R5: With `mode` = 1 (toggle), `clk_out` inverts after each event step and keeps its value after a step with no event.
- R6: When den = 0 or num ≥ den, `cfg_err` is high in the same cycle. In the cycle after each such edge, `clk_out` and `wrap_stb` are low, and the accumulator is frozen.
- R7: A cycle in which `ratio_num` or `ratio_den` differs from its value at the previous edge clears the accumulator and produces no event. In pulse mode it also drives `clk_out` low.
- R8: While `en` is low, the accumulator and `clk_out` keep their values and `wrap_stb` is low.
- R9: When num divides den, consecutive events are spaced exactly den/num cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Step enable; low holds all state |
| mode | input | 1 | 0 = single-cycle pulse, 1 = toggled square wave |
| ratio_num | input | W | Numerator added on each step |
| ratio_den | input | W | Modulus of the accumulator |
| clk_out | output | 1 | Registered divided output |
| wrap_stb | output | 1 | One-cycle overflow strobe |
| cfg_err | output | 1 | Ratio invalid (den = 0 or num ≥ den) |

## Verification
The accumulator is the only hidden state. A wrong value in it first appears as an event strobe that lands one or more cycles early or late, and the bench sees this on `wrap_stb` within one denominator period of the fault. A behavioural model runs next to the design and is compared on every clock, so the first misplaced strobe, toggle or error flag is reported in the cycle it appears. Event counts over long runs also catch slow drift, such as a wrong subtraction that keeps individual edges plausible but changes the long-run rate.

// File: rtl/fcd_pkg.sv
// Shared types for the rational fractional clock divider.
package fcd_pkg;
    // Output shaping selected by the mode pin.
    typedef enum logic {
        FCD_PULSE  = 1'b0,
        FCD_TOGGLE = 1'b1
    } fcd_mode_e;
endpackage

// File: rtl/fcd_cfg_watch.sv
// Configuration watcher.
// Checks the ratio for validity and spots any change of numerator or
// denominator since the previous edge.
// Assumes: ratio inputs are synchronous to clk.
module fcd_cfg_watch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         cfg_chg,
    output logic         cfg_bad
);
    logic [W-1:0] num_q;
    logic [W-1:0] den_q;

    // Remember the ratio seen at the last edge; reset loads the present one.
    always_ff @(posedge clk) begin
        num_q <= num;
        den_q <= den;
    end

    assign cfg_chg = rst_n && ((num != num_q) || (den != den_q));
    assign cfg_bad = (den == '0) || (num >= den);
endmodule

// File: rtl/fcd_phase_acc.sv
// Modulo-den phase accumulator.
// Adds num on each step and, when the sum would pass den, takes den off
// and raises hit for that step.
// Assumes: num < den whenever step is high (the caller gates invalid ratios).
module fcd_phase_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    input  logic         step,
    input  logic         clr,
    output logic         hit
);
    localparam int AW = W + 1;

    logic [AW-1:0] acc_q;
    logic [AW-1:0] num_x;
    logic [AW-1:0] den_x;
    logic [AW-1:0] thresh;

    assign num_x  = {1'b0, num};
    assign den_x  = {1'b0, den};
    assign thresh = den_x - num_x;
    assign hit    = step && (acc_q > thresh);

    // Accumulator update: clear on reset or ratio change, wrap on hit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (step) begin
            if (hit) acc_q <= acc_q + num_x - den_x;
            else     acc_q <= acc_q + num_x;
        end
    end

    // R3: a step with a steady ratio leaves the accumulator within den.
    p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (acc_q <= {1'b0, $past(den)}));

    // R7: a ratio change leaves a cleared accumulator.
    p_clear_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));

    // R8: with no step and no clear the accumulator holds.
    p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(acc_q));
endmodule

// File: rtl/fcd_out_stage.sv
// Output register stage.
// Turns accumulator hits into a registered strobe and a pulse or toggle
// output, so the pins come straight from flip-flops.
// Assumes: hit is only high when step is high.
module fcd_out_stage
    import fcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  logic      step,
    input  logic      bad,
    input  logic      chg,
    input  fcd_mode_e mode,
    output logic      clk_out,
    output logic      wrap_stb
);
    logic out_q;
    logic stb_q;

    // Strobe register: marks each overflow for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= hit;
    end

    // Output register: silence on error, shape by mode on a step.
    always_ff @(posedge clk) begin
        if (!rst_n || bad) begin
            out_q <= 1'b0;
        end else if (chg) begin
            if (mode == FCD_PULSE) out_q <= 1'b0;
        end else if (step) begin
            if (mode == FCD_PULSE) out_q <= hit;
            else                   out_q <= out_q ^ hit;
        end
    end

    assign clk_out  = out_q;
    assign wrap_stb = stb_q;

    // R6: an invalid ratio leaves both outputs low.
    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> (!clk_out && !wrap_stb));

    // R4: in pulse mode the output follows the strobe after each step.
    p_pulse_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == FCD_PULSE) |=> (clk_out == wrap_stb));

    // R5: in toggle mode the output flips exactly when a strobe appears.
    p_toggle_on_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == FCD_TOGGLE) |=> ((clk_out != $past(clk_out)) == wrap_stb));

    // R2: no strobe follows a cycle without a step.
    p_strobe_needs_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> !wrap_stb);
endmodule

// File: rtl/frac_clk_div.sv
// Rational fractional clock divider, top level.
// Produces events at Fsys*num/den from a modulo-den accumulator and shapes
// them into a one-cycle pulse or a toggled square wave.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module frac_clk_div
    import fcd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         mode,
    input  logic [W-1:0] ratio_num,
    input  logic [W-1:0] ratio_den,
    output logic         clk_out,
    output logic         wrap_stb,
    output logic         cfg_err
);
    logic      cfg_chg;
    logic      cfg_bad;
    logic      step;
    logic      hit;
    fcd_mode_e mode_e;

    assign mode_e  = fcd_mode_e'(mode);
    assign step    = en && !cfg_bad && !cfg_chg;
    assign cfg_err = cfg_bad;

    fcd_cfg_watch #(.W(W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .num     (ratio_num),
        .den     (ratio_den),
        .cfg_chg (cfg_chg),
        .cfg_bad (cfg_bad)
    );

    fcd_phase_acc #(.W(W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .num   (ratio_num),
        .den   (ratio_den),
        .step  (step),
        .clr   (cfg_chg),
        .hit   (hit)
    );

    fcd_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .step     (step),
        .bad      (cfg_bad),
        .chg      (cfg_chg),
        .mode     (mode_e),
        .clk_out  (clk_out),
        .wrap_stb (wrap_stb)
    );

    // R8: with enable low no strobe is produced.
    p_no_strobe_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !wrap_stb);
endmodule

// File: tb/frac_clk_div_tb.sv
module frac_clk_div_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] ratio_num = 8'd3;
    logic [W-1:0] ratio_den = 8'd8;
    logic         clk_out;
    logic         wrap_stb;
    logic         cfg_err;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    int m_acc = 0;
    int m_num = 0;
    int m_den = 0;
    bit m_out = 0;
    bit m_stb = 0;

    always #5 clk = ~clk;

    frac_clk_div #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
        .ratio_num(ratio_num), .ratio_den(ratio_den),
        .clk_out(clk_out), .wrap_stb(wrap_stb), .cfg_err(cfg_err)
    );

    // Behavioural reference, stepped at each rising edge from the requirements.
    always @(posedge clk) begin
        int  a;
        int  b;
        bit  chg;
        bit  bad;
        bit  ev;
        a = int'(ratio_num);
        b = int'(ratio_den);
        chg = (a != m_num) || (b != m_den);
        bad = (b == 0) || (a >= b);
        m_num = a;
        m_den = b;
        if (!rst_n) begin
            m_acc = 0; m_out = 0; m_stb = 0;
        end else if (chg) begin
            m_acc = 0; m_stb = 0;
            if (bad || !mode) m_out = 0;
        end else if (bad) begin
            m_stb = 0; m_out = 0;
        end else if (!en) begin
            m_stb = 0;
        end else begin
            ev = (m_acc > b - a);
            m_acc = ev ? m_acc + a - b : m_acc + a;
            m_stb = ev;
            m_out = mode ? (m_out ^ ev) : ev;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp, string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Advance one clock and compare all outputs with the model.
    task automatic tick();
        @(posedge clk);
        #1;
        chk(clk_out == m_out, cur_req, clk_out, m_out, "clk_out vs model");
        chk(wrap_stb == m_stb, cur_req, wrap_stb, m_stb, "wrap_stb vs model");
        chk(cfg_err == ((ratio_den == 0) || (ratio_num >= ratio_den)), "R6",
            cfg_err, (ratio_den == 0) || (ratio_num >= ratio_den), "cfg_err");
    endtask

    task automatic do_reset(int a, int b, bit m);
        rst_n = 1'b0; en = 1'b0; ratio_num = a[W-1:0]; ratio_den = b[W-1:0]; mode = m;
        cur_req = "R1";
        repeat (3) tick();
        chk(clk_out == 0, "R1", clk_out, 0, "clk_out in reset");
        chk(wrap_stb == 0, "R1", wrap_stb, 0, "wrap_stb in reset");
        rst_n = 1'b1; en = 1'b1;
    endtask

    function automatic int exp_events(int n, int a, int b);
        return (n * a - 1) / b;
    endfunction

    initial begin
        int cnt;
        int last;
        int gap_bad;
        bit held;

        // R2, R3, R4: pulse mode 3/8
        do_reset(3, 8, 1'b0);
        cur_req = "R2";
        cnt = 0;
        for (int i = 0; i < 80; i++) begin
            tick();
            cnt += wrap_stb;
            chk(clk_out == wrap_stb, "R4", clk_out, wrap_stb, "pulse equals strobe");
        end
        chk(cnt == exp_events(80, 3, 8), "R3", cnt, exp_events(80, 3, 8), "event count 3/8");

        // R4: back-to-back events 7/8
        do_reset(7, 8, 1'b0);
        cur_req = "R4";
        cnt = 0;
        for (int i = 0; i < 64; i++) begin tick(); cnt += wrap_stb; end
        chk(cnt == exp_events(64, 7, 8), "R3", cnt, exp_events(64, 7, 8), "event count 7/8");

        // R5, R9: toggle mode 1/4, integer division
        do_reset(1, 4, 1'b1);
        cur_req = "R5";
        cnt = 0; last = -1; gap_bad = 0;
        for (int i = 0; i < 40; i++) begin
            bit prev;
            prev = clk_out;
            tick();
            if (clk_out != prev) begin
                cnt++;
                if (last >= 0 && (i - last) != 4) gap_bad++;
                last = i;
            end
        end
        chk(cnt == exp_events(40, 1, 4), "R5", cnt, exp_events(40, 1, 4), "toggle count 1/4");
        chk(gap_bad == 0, "R9", gap_bad, 0, "uneven spacing at integer ratio");

        // R8: enable low holds output, no strobe
        cur_req = "R8";
        for (int i = 0; i < 5; i++) tick();
        en = 1'b0;
        held = clk_out;
        for (int i = 0; i < 10; i++) begin
            tick();
            chk(clk_out == held, "R8", clk_out, held, "clk_out held");
            chk(wrap_stb == 0, "R8", wrap_stb, 0, "no strobe disabled");
        end
        en = 1'b1;
        for (int i = 0; i < 20; i++) tick();

        // R7: ratio change clears accumulator
        do_reset(5, 9, 1'b0);
        cur_req = "R7";
        for (int i = 0; i < 7; i++) tick();
        ratio_num = 8'd2;
        tick();
        chk(wrap_stb == 0, "R7", wrap_stb, 0, "no event on change cycle");
        chk(clk_out == 0, "R7", clk_out, 0, "pulse output cleared on change");
        cnt = 0;
        for (int i = 0; i < 45; i++) begin tick(); cnt += wrap_stb; end
        chk(cnt == exp_events(45, 2, 9), "R7", cnt, exp_events(45, 2, 9), "count restarts from zero");

        // R6: invalid ratios
        mode = 1'b1;
        cur_req = "R6";
        for (int i = 0; i < 6; i++) tick();
        ratio_num = 8'd9; ratio_den = 8'd8;
        #1;
        chk(cfg_err == 1, "R6", cfg_err, 1, "error for num >= den");
        for (int i = 0; i < 8; i++) begin
            tick();
            chk(clk_out == 0 && wrap_stb == 0, "R6", {clk_out, wrap_stb}, 0, "quiet on error");
        end
        ratio_num = 8'd1; ratio_den = 8'd0;
        #1;
        chk(cfg_err == 1, "R6", cfg_err, 1, "error for den = 0");
        for (int i = 0; i < 5; i++) tick();
        ratio_num = 8'd1; ratio_den = 8'd3;
        for (int i = 0; i < 30; i++) tick();

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule